// File: doc/BRIEF.md
# Serial Port Register Block

This block is a byte-wide, register-mapped asynchronous serial port for a small processor's I/O space. Software selects a bit rate with a rate code. It sets the character shape at run time: five to eight data bits, odd, even or no parity, and one or two stop bits. Software then writes bytes to send and reads bytes that have arrived. A status register reports the receiver holding an unread byte, the transmitter being idle, a framing or parity fault on the held byte, and a byte lost to overwrite.

Two enable bits route the receive-ready and transmit-idle conditions onto a single level interrupt request. While the processor holds its acknowledge input high, the block presents an 8-bit interrupt type that software has programmed. The processor uses that type to find the handler. The transmitter and receiver each time their bits from their own clock counter. The receiver resynchronises on each start edge and samples every bit at its centre.

Top module: `serial_port_regs`

## Requirements
- R1: After reset, STATUS reads 0x02, the rate register reads the 9600 code 0x0D, the shape register reads 0x13, irq is low and txd is high.
- R2: The shape register (address 2) bits [1:0] give the data bit count (0→5, 1→6, 2→7, 3→8). A frame is a low start bit followed by the data bits, least significant first.
- R3: Shape bits [4:3] select parity: 00 odd, 01 even, 1x none. When enabled, one parity bit follows the data bits and makes the count of ones in data plus parity odd or even.
- R4: Shape bit 2 selects one stop bit (0) or two (1). Stop bits are high.
- R5: The rate register (address 1) code c = bits [3:0] gives a bit time of 16·max(1, B·2^(13−c)) clocks, where B = floor(CLK_HZ/153600). For c above 13, the power of two divides and the result is truncated. Code 0x0D gives 9600 baud.
- R6: STATUS bit 1 (TxREADY) drops in the cycle after a write to TX data (address 5) and rises when the last stop bit ends. A TX data write while TxREADY is 0 is dropped.
- R7: STATUS bit 0 (RxREADY) rises when a frame's last stop bit is sampled. RX data (address 6) returns the received bits right-aligned, with the unused upper bits zero. Reading it clears RxREADY.
- R8: A frame with a parity mismatch or a low stop bit still sets RxREADY. It also sets STATUS bit 2, which each later frame rewrites.
- R9: A frame completed while RxREADY is 1 overwrites RX data and sets STATUS bit 3. Reading RX data clears bit 3.
- R10: irq = (INT_CTL bit 0 and RxREADY) or (INT_CTL bit 1 and TxREADY). INT_CTL is at address 4, so writing 0x01 enables only the receive source.
- R11: itype equals the TYPE register (address 0) while iack is high and is 0 otherwise.
- R12: The rate, shape (5 bits), INT_CTL (2 bits) and TYPE registers read back what was written, with unused bits zero. Writes to STATUS (address 3) have no effect.
- R13: A low pulse on rxd that is gone before the middle of the start bit produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register access strobe, one cycle per access |
| wr | input | 1 | 1 for write, 0 for read |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| irq | output | 1 | Level interrupt request |
| iack | input | 1 | Interrupt acknowledge |
| itype | output | 8 | Interrupt type while acknowledged |

## Verification
The bench builds the block with CLK_HZ = 307200, which makes B equal to 2. Rate codes 12 to 15 then give bit times of 64, 32, 16 and 16 clocks, so both the divide and the clamp of the rate rule can be measured directly. With frames that short, all 32 shape register values can be swept in both directions. On receive, every parity-bearing shape also gets a frame with a corrupted parity bit. Overrun, a bad stop bit, a runt start pulse and a dropped busy write are each run once.

// File: rtl/serial_port_regs.sv
module serial_port_regs #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int REF_BAUD = 9600,
  parameter int REF_CODE = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       irq,
  input  logic       iack,
  output logic [7:0] itype
);
  localparam int BASE_I = CLK_HZ / (16 * REF_BAUD);
  localparam int BASE   = (BASE_I < 1) ? 1 : BASE_I;
  localparam int CW     = $clog2(16 * (BASE << REF_CODE) + 1);

  localparam logic [2:0] A_TYPE = 3'd0, A_SPD = 3'd1, A_LINE = 3'd2, A_STAT = 3'd3,
                         A_IEN = 3'd4, A_TXD = 3'd5, A_RXD = 3'd6;

  logic [7:0] type_r, speed_r;
  logic [4:0] line_r;
  logic [1:0] ien_r;

  logic [CW-1:0] div, bitp, half;
  logic [3:0]    nd, flen;
  logic          has_par;

  logic          wr_en, wr_tx, rd_rx;
  assign wr_en = sel & wr;
  assign wr_tx = wr_en & (addr == A_TXD);
  assign rd_rx = sel & ~wr & (addr == A_RXD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_r  <= 8'h00;
      speed_r <= 8'(REF_CODE);
      line_r  <= 5'h13;
      ien_r   <= 2'b00;
    end else if (wr_en) begin
      case (addr)
        A_TYPE:  type_r  <= wdata;
        A_SPD:   speed_r <= wdata;
        A_LINE:  line_r  <= wdata[4:0];
        A_IEN:   ien_r   <= wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    if (speed_r[3:0] <= 4'(REF_CODE))
      div = CW'(BASE) << (4'(REF_CODE) - speed_r[3:0]);
    else
      div = CW'(BASE) >> (speed_r[3:0] - 4'(REF_CODE));
    if (div == '0) div = CW'(1);
  end
  assign bitp = div << 4;
  assign half = div << 3;

  assign nd      = 4'd5 + {2'b00, line_r[1:0]};
  assign has_par = ~line_r[4];
  assign flen    = 4'd2 + nd + {3'b000, has_par} + {3'b000, line_r[2]};

  // transmitter
  logic [7:0]    dmask;
  logic          pbit;
  logic [11:0]   tx_fr, tx_sh;
  logic [CW-1:0] tx_cnt;
  logic [3:0]    tx_left;
  logic          tx_ready;

  assign dmask = wdata & (8'hFF >> (4'd8 - nd));
  assign pbit  = line_r[3] ? ^dmask : ~^dmask;

  always_comb begin
    tx_fr    = '1;
    tx_fr[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (4'(i) < nd) tx_fr[i+1] = wdata[i];
    if (has_par) tx_fr[nd + 4'd1] = pbit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh    <= '1;
      tx_cnt   <= '0;
      tx_left  <= '0;
      tx_ready <= 1'b1;
    end else if (wr_tx && tx_ready) begin
      tx_sh    <= tx_fr;
      tx_cnt   <= bitp - CW'(1);
      tx_left  <= flen;
      tx_ready <= 1'b0;
    end else if (!tx_ready) begin
      if (tx_cnt == '0) begin
        tx_sh   <= {1'b1, tx_sh[11:1]};
        tx_cnt  <= bitp - CW'(1);
        tx_left <= tx_left - 4'd1;
        if (tx_left == 4'd1) tx_ready <= 1'b1;
      end else begin
        tx_cnt <= tx_cnt - CW'(1);
      end
    end
  end
  assign txd = tx_sh[0];

  // receiver
  logic          rx_s1, rx_s2, rx_s3, rx_act, rx_par, rx_bad;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_idx;
  logic [7:0]    rx_sh, rx_byte, rx_data;
  logic          rx_samp, rx_is_data, rx_is_par, rx_last, rx_deliver, perr, serr;
  logic          rx_ready, rx_err, rx_ovr;

  assign rx_samp    = rx_act && (rx_cnt == '0);
  assign rx_is_data = (rx_idx != 4'd0) && (rx_idx <= nd);
  assign rx_is_par  = has_par && (rx_idx == nd + 4'd1);
  assign rx_last    = (rx_idx == flen - 4'd1);
  assign rx_deliver = rx_samp && rx_last;
  assign rx_byte    = rx_sh >> (4'd8 - nd);
  assign perr       = has_par && (line_r[3] ? rx_par : ~rx_par);
  assign serr       = rx_bad | ~rx_s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s1  <= 1'b1;
      rx_s2  <= 1'b1;
      rx_s3  <= 1'b1;
      rx_act <= 1'b0;
      rx_cnt <= '0;
      rx_idx <= '0;
      rx_sh  <= '0;
      rx_par <= 1'b0;
      rx_bad <= 1'b0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      rx_s3 <= rx_s2;
      if (!rx_act) begin
        if (rx_s3 && !rx_s2) begin
          rx_act <= 1'b1;
          rx_cnt <= half - CW'(1);
          rx_idx <= 4'd0;
          rx_par <= 1'b0;
          rx_bad <= 1'b0;
        end
      end else if (rx_samp) begin
        rx_cnt <= bitp - CW'(1);
        rx_idx <= rx_idx + 4'd1;
        if (rx_idx == 4'd0) begin
          if (rx_s2) rx_act <= 1'b0;
        end else if (rx_is_data) begin
          rx_sh  <= {rx_s2, rx_sh[7:1]};
          rx_par <= rx_par ^ rx_s2;
        end else if (rx_is_par) begin
          rx_par <= rx_par ^ rx_s2;
        end else if (!rx_s2) begin
          rx_bad <= 1'b1;
        end
        if (rx_last) rx_act <= 1'b0;
      end else begin
        rx_cnt <= rx_cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_ready <= 1'b0;
      rx_err   <= 1'b0;
      rx_ovr   <= 1'b0;
    end else if (rx_deliver) begin
      rx_data  <= rx_byte;
      rx_ready <= 1'b1;
      rx_ovr   <= rx_ready & ~rd_rx;
      rx_err   <= perr | serr;
    end else if (rd_rx) begin
      rx_ready <= 1'b0;
      rx_ovr   <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_TYPE:  rdata = type_r;
      A_SPD:   rdata = speed_r;
      A_LINE:  rdata = {3'b000, line_r};
      A_STAT:  rdata = {4'b0000, rx_ovr, rx_err, tx_ready, rx_ready};
      A_IEN:   rdata = {6'b000000, ien_r};
      A_RXD:   rdata = rx_data;
      default: rdata = 8'h00;
    endcase
  end

  assign irq   = (ien_r[0] & rx_ready) | (ien_r[1] & tx_ready);
  assign itype = iack ? type_r : 8'h00;

  a_r6_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);
  a_r6_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && tx_ready) |=> (!tx_ready && !txd));
  a_r7_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_deliver) |=> !rx_ready);
  a_r9_overrun_needs_held_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_ready));
  a_r8_error_comes_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_err) |-> rx_ready);
  a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_ready || tx_ready));
endmodule

// File: tb/serial_port_regs_tb_top.sv
module serial_port_regs_tb_top;
  localparam int CLK_HZ = 307200;
  localparam int BASE   = CLK_HZ / 153600;

  logic clk = 1'b0;
  logic rst_n, sel, wr, rxd, iack;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, itype;
  logic txd, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_port_regs #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .txd(txd), .rxd(rxd), .irq(irq), .iack(iack), .itype(itype));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  function automatic int bit_time(input int code);
    int dv;
    if (code <= 13) dv = BASE << (13 - code);
    else dv = BASE >> (code - 13);
    if (dv < 1) dv = 1;
    return 16 * dv;
  endfunction

  function automatic void mk_frame(input logic [4:0] lc, input logic [7:0] d,
                                   output logic [11:0] b, output int n);
    int nd;
    logic p;
    nd = 5 + int'(lc[1:0]);
    b = '1;
    b[0] = 1'b0;
    p = lc[3] ? 1'b0 : 1'b1;
    for (int i = 0; i < nd; i++) begin
      b[1+i] = d[i];
      p = p ^ d[i];
    end
    n = 1 + nd;
    if (!lc[4]) begin
      b[n] = p;
      n++;
    end
    n += lc[2] ? 2 : 1;
  endfunction

  // caller has just returned from the TX data write (half a cycle after the edge)
  task automatic collect_tx(input int p, input int lead, input int n, output logic [11:0] got);
    got = '1;
    for (int k = 0; k < n; k++) begin
      repeat (k == 0 ? p/2 - lead : p) @(negedge clk);
      got[k] = txd;
    end
    repeat (p/2 + 1) @(negedge clk);
  endtask

  task automatic rx_send(input logic [11:0] b, input int n, input int p);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rxd = b[k];
      repeat (p - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic [11:0] eb, gb;
    int n, cnt;
    rst_n = 0; sel = 0; wr = 0; addr = 0; wdata = 0; rxd = 1; iack = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_reg(3'd3, rv); chk("R1 status", rv, 8'h02);
    rd_reg(3'd1, rv); chk("R1 speed", rv, 8'h0D);
    rd_reg(3'd2, rv); chk("R1 line", rv, 8'h13);
    chk("R1 irq", irq, 1'b0);
    chk("R1 txd", txd, 1'b1);

    // R12 readback
    wr_reg(3'd1, 8'h0E); rd_reg(3'd1, rv); chk("R12 speed", rv, 8'h0E);
    wr_reg(3'd2, 8'hFF); rd_reg(3'd2, rv); chk("R12 line", rv, 8'h1F);
    wr_reg(3'd4, 8'hFF); rd_reg(3'd4, rv); chk("R12 int_ctl", rv, 8'h03);
    wr_reg(3'd0, 8'hA7); rd_reg(3'd0, rv); chk("R12 type", rv, 8'hA7);
    wr_reg(3'd3, 8'hFF); rd_reg(3'd3, rv); chk("R12 status write ignored", rv, 8'h02);
    wr_reg(3'd4, 8'h00); wr_reg(3'd2, 8'h13);

    // R5 bit time per rate code
    for (int c = 12; c <= 15; c++) begin
      wr_reg(3'd1, 8'(c));
      wr_reg(3'd5, 8'h55);
      cnt = 0;
      while (txd == 1'b0 && cnt < 1000) begin
        cnt++;
        @(negedge clk);
      end
      chk($sformatf("R5 bit time code %0d", c), cnt, bit_time(c));
      repeat (12 * bit_time(c)) @(negedge clk);
    end

    // R2 R3 R4 R6 transmit sweep over every shape value
    wr_reg(3'd1, 8'h0E);
    for (int lc = 0; lc < 32; lc++) begin
      logic [7:0] d;
      d = 8'h3C ^ 8'(lc * 37);
      wr_reg(3'd2, 8'(lc));
      mk_frame(5'(lc), d, eb, n);
      wr_reg(3'd5, d);
      collect_tx(16, 0, n, gb);
      chk($sformatf("R2 R3 R4 tx frame line=%0h", lc), gb, eb);
      rd_reg(3'd3, rv);
      chk("R6 txready after frame", rv[1], 1'b1);
    end

    // R6 busy behaviour and dropped write
    wr_reg(3'd1, 8'h0D);
    wr_reg(3'd2, 8'h13);
    mk_frame(5'h13, 8'hC3, eb, n);
    wr_reg(3'd5, 8'hC3);
    rd_reg(3'd3, rv);
    chk("R6 txready low while busy", rv[1], 1'b0);
    wr_reg(3'd5, 8'hFF);
    collect_tx(32, 4, n, gb);
    chk("R6 busy write dropped", gb, eb);
    repeat (40) @(negedge clk);
    chk("R6 line idle after frame", txd, 1'b1);

    // R7 R8 R3 receive sweep
    wr_reg(3'd1, 8'h0E);
    for (int lc = 0; lc < 32; lc++) begin
      logic [7:0] d, m;
      d = 8'h96 ^ 8'(lc * 53);
      m = 8'hFF >> (3 - lc % 4);
      wr_reg(3'd2, 8'(lc));
      mk_frame(5'(lc), d, eb, n);
      rx_send(eb, n, 16);
      rd_reg(3'd3, rv);
      chk($sformatf("R7 rx status line=%0h", lc), rv, 8'h03);
      rd_reg(3'd6, rv);
      chk($sformatf("R7 rx data line=%0h", lc), rv, d & m);
      rd_reg(3'd3, rv);
      chk("R7 read clears ready", rv[0], 1'b0);
      if (!lc[4]) begin
        eb[6 + lc % 4] = ~eb[6 + lc % 4];
        rx_send(eb, n, 16);
        rd_reg(3'd3, rv);
        chk($sformatf("R8 parity error line=%0h", lc), rv, 8'h07);
        rd_reg(3'd6, rv);
        chk("R8 data kept on parity error", rv, d & m);
      end
    end

    // R8 bad stop bit
    wr_reg(3'd2, 8'h13);
    mk_frame(5'h13, 8'h5A, eb, n);
    eb[9] = 1'b0;
    rx_send(eb, n, 16);
    repeat (32) @(negedge clk);
    rd_reg(3'd3, rv); chk("R8 stop error", rv, 8'h07);
    rd_reg(3'd6, rv); chk("R8 stop error data", rv, 8'h5A);

    // R9 overrun
    mk_frame(5'h13, 8'h11, eb, n); rx_send(eb, n, 16);
    mk_frame(5'h13, 8'h22, eb, n); rx_send(eb, n, 16);
    rd_reg(3'd3, rv); chk("R9 overrun status", rv, 8'h0B);
    rd_reg(3'd6, rv); chk("R9 newest byte kept", rv, 8'h22);
    rd_reg(3'd3, rv); chk("R9 read clears overrun", rv, 8'h02);

    // R13 runt start pulse
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (48) @(negedge clk);
    rd_reg(3'd3, rv); chk("R13 runt ignored", rv[0], 1'b0);

    // R10 interrupt routing
    chk("R10 no enables", irq, 1'b0);
    wr_reg(3'd4, 8'h02); #1 chk("R10 tx enable idle", irq, 1'b1);
    wr_reg(3'd4, 8'h01); #1 chk("R10 rx enable empty", irq, 1'b0);
    mk_frame(5'h13, 8'h7E, eb, n); rx_send(eb, n, 16);
    chk("R10 rx irq raised", irq, 1'b1);
    rd_reg(3'd6, rv);
    #1 chk("R10 rx irq cleared", irq, 1'b0);
    wr_reg(3'd4, 8'h00);

    // R11 acknowledge type
    wr_reg(3'd0, 8'h5A);
    #1 chk("R11 type hidden", itype, 8'h00);
    iack = 1'b1; #1 chk("R11 type on ack", itype, 8'h5A);
    iack = 1'b0; #1 chk("R11 type released", itype, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule